// File: doc/BRIEF.md
# Pixel Row Hit Sparsifier

This block sits beside one row of binary pixel comparators in a calorimeter sensor. While a bunch train is running, every bunch-crossing strobe captures the row's hit flags. Noisy pixels are cleared by a mask. The row is then cut into fixed groups of adjacent pixels. For every group with at least one surviving hit, one compact record goes into a local record memory. The record carries the crossing count within the train, the group index and that group's hit pattern. Empty groups cost nothing.

Between trains the block is told to read out. It presents the stored records one at a time with the row code prefixed. After the records it presents a closing trailer word. Once the trailer is taken, the memory is empty again. The mask is shifted in serially while no train is running.

Top module: `row_hit_sparsifier`

## Requirements
- R1: After reset no records are held and `out_valid` is low. A readout requested right after reset gives only the trailer word: `out_last`=1, `out_ovf`=0, data = {row, 22'b0}.
- R2: Each record word is {row[30:22], timestamp[21:9], group[8:6], pattern[5:0]}. Group g covers pixels 6g to 6g+5, and pattern bit i is pixel 6g+i. Exactly one record is produced per group with a nonzero masked pattern, and none for a crossing with no masked hits.
- R3: When several groups are hit in one crossing, their records are written one per clock in ascending group index order, and they read out in that order.
- R4: A pixel whose mask bit is 1 never contributes to a pattern. The mask loads by serial shift: the bit shifted in first ends at pixel 41 after 42 shifts.
- R5: Mask shift pulses during a train have no effect on the mask.
- R6: The timestamp is 0 for the first crossing after train start and rises by 1 with each later crossing of the train.
- R7: The timestamp saturates at 8191 and does not wrap.
- R8: With the memory full (default 16 records), further records are dropped. The earliest records are kept, and `out_ovf` is high on every word of the following readout.
- R9: Crossing strobes outside a train create no records.
- R10: Readout uses valid/ready. `out_data` is held stable while `out_ready` is low. Records appear in write order and are followed by one trailer with `out_last`=1. Once the trailer is accepted, `out_valid` drops, and both the record count and the overflow flag are cleared.
- R11: A readout request during a train is ignored: `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_start | input | 1 | Begin a train (accepted when idle) |
| train_stop | input | 1 | End the train |
| xing | input | 1 | Bunch-crossing strobe, samples `hit` |
| hit | input | 42 | Per-pixel hit flags |
| mask_din | input | 1 | Serial mask data |
| mask_shift | input | 1 | Shift one mask bit in (idle only) |
| rd_req | input | 1 | Start readout (idle only) |
| row_addr | input | 9 | Row code added to each output word |
| out_ready | input | 1 | Consumer accepts the word |
| out_valid | output | 1 | Word available |
| out_data | output | 31 | Row code and record, or trailer |
| out_last | output | 1 | Marks the trailer word |
| out_ovf | output | 1 | Overflow flag, shown during readout |

## Verification
A crossing strobe is captured at one rising edge. The first group's record is written at the next edge, and the remaining groups follow one per edge. The bench therefore leaves eight idle cycles after every crossing before the next one or before stopping the train. Readout words are valid from the first edge after the request. The bench samples every output at the falling edge and advances one word per accepted transfer. It checks each word against records computed from the vectors, the bench's own mask copy and its own crossing count. The checks on stability and on the idle state look at the cycle just after the stimulus.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_TRAIN = 2'd1,
      ST_READ  = 2'd2
   } rhs_state_e;
endpackage

// File: rtl/rhs_mask.sv
module rhs_mask #(
   parameter int PIX = 42
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shift_en,
   input  logic           din,
   output logic [PIX-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask <= '0;
      else if (shift_en) mask <= {mask[PIX-2:0], din};
   end
endmodule

// File: rtl/rhs_capture.sv
module rhs_capture #(
   parameter int PIX         = 42,
   parameter int GRP_W       = 6,
   parameter int TS_W        = 13,
   parameter bit TS_SATURATE = 1'b1,
   localparam int NGRP  = PIX / GRP_W,
   localparam int GI_W  = (NGRP > 1) ? $clog2(NGRP) : 1,
   localparam int REC_W = TS_W + GI_W + GRP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_train,
   input  logic             start_go,
   input  logic             stop_go,
   input  logic             xing,
   input  logic [PIX-1:0]   hit,
   input  logic [PIX-1:0]   mask,
   output logic             wr_en,
   output logic [REC_W-1:0] wr_rec,
   output logic [TS_W-1:0]  ts
);
   logic [PIX-1:0]  pend_pat;
   logic [TS_W-1:0] pend_ts;
   logic [TS_W-1:0] ts_next;
   logic [NGRP-1:0] grp_any;
   logic [GI_W-1:0] sel;

   generate
      for (genvar g = 0; g < NGRP; g++) begin : g_any
         assign grp_any[g] = |pend_pat[g*GRP_W +: GRP_W];
      end
      if (TS_SATURATE) begin : g_sat
         assign ts_next = (ts == {TS_W{1'b1}}) ? ts : ts + TS_W'(1);
      end else begin : g_wrap
         assign ts_next = ts + TS_W'(1);
      end
   endgenerate

   always_comb begin
      sel = '0;
      for (int g = NGRP - 1; g >= 0; g--)
         if (grp_any[g]) sel = GI_W'(g);
   end

   assign wr_en  = (|grp_any) && in_train;
   assign wr_rec = {pend_ts, sel, pend_pat[int'(sel)*GRP_W +: GRP_W]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_pat <= '0;
         pend_ts  <= '0;
         ts       <= '0;
      end else if (start_go) begin
         pend_pat <= '0;
         ts       <= '0;
      end else if (stop_go) begin
         pend_pat <= '0;
      end else if (xing && in_train) begin
         pend_pat <= hit & ~mask;
         pend_ts  <= ts;
         ts       <= ts_next;
      end else if (|grp_any) begin
         pend_pat[int'(sel)*GRP_W +: GRP_W] <= '0;
      end
   end
endmodule

// File: rtl/rhs_store.sv
module rhs_store #(
   parameter int REC_W = 22,
   parameter int DEPTH = 16,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REC_W-1:0] wr_rec,
   input  logic             clr,
   input  logic [AW-1:0]    rd_idx,
   output logic [REC_W-1:0] rd_rec,
   output logic [CW-1:0]    cnt,
   output logic             ovf
);
   logic [REC_W-1:0] mem [DEPTH];
   logic             room;

   assign room   = cnt < CW'(DEPTH);
   assign rd_rec = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (wr_en && room) mem[cnt[AW-1:0]] <= wr_rec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (clr) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else if (wr_en) begin
         if (room) cnt <= cnt + CW'(1);
         else      ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/row_hit_sparsifier.sv
module row_hit_sparsifier #(
   parameter int PIX         = 42,
   parameter int GRP_W       = 6,
   parameter int TS_W        = 13,
   parameter int ROW_W       = 9,
   parameter int DEPTH       = 16,
   parameter bit TS_SATURATE = 1'b1,
   localparam int NGRP  = PIX / GRP_W,
   localparam int GI_W  = (NGRP > 1) ? $clog2(NGRP) : 1,
   localparam int REC_W = TS_W + GI_W + GRP_W,
   localparam int OUT_W = ROW_W + REC_W,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             train_start,
   input  logic             train_stop,
   input  logic             xing,
   input  logic [PIX-1:0]   hit,
   input  logic             mask_din,
   input  logic             mask_shift,
   input  logic             rd_req,
   input  logic [ROW_W-1:0] row_addr,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data,
   output logic             out_last,
   output logic             out_ovf
);
   import rhs_pkg::*;

   generate
      if (PIX % GRP_W != 0) begin : g_bad_split
         $error("PIX must be a multiple of GRP_W");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("DEPTH must be at least 1");
      end
      if (TS_W < 1 || ROW_W < 1) begin : g_bad_width
         $error("TS_W and ROW_W must be positive");
      end
   endgenerate

   rhs_state_e       state;
   logic             in_train, start_go, stop_go;
   logic [PIX-1:0]   mask;
   logic             wr_en;
   logic [REC_W-1:0] wr_rec, rd_rec;
   logic [TS_W-1:0]  ts_now;
   logic [CW-1:0]    rec_cnt, rptr;
   logic             ovf, at_trailer, take, clr;

   assign in_train   = (state == ST_TRAIN);
   assign start_go   = train_start && (state == ST_IDLE);
   assign stop_go    = train_stop && in_train;
   assign out_valid  = (state == ST_READ);
   assign at_trailer = (rptr == rec_cnt);
   assign take       = out_valid && out_ready;
   assign clr        = take && at_trailer;
   assign out_last   = out_valid && at_trailer;
   assign out_ovf    = out_valid && ovf;
   assign out_data   = at_trailer ? {row_addr, {REC_W{1'b0}}} : {row_addr, rd_rec};

   rhs_mask #(.PIX(PIX)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .shift_en(mask_shift && (state == ST_IDLE)),
      .din(mask_din), .mask(mask)
   );

   rhs_capture #(.PIX(PIX), .GRP_W(GRP_W), .TS_W(TS_W), .TS_SATURATE(TS_SATURATE)) u_cap (
      .clk(clk), .rst_n(rst_n), .in_train(in_train),
      .start_go(start_go), .stop_go(stop_go), .xing(xing),
      .hit(hit), .mask(mask), .wr_en(wr_en), .wr_rec(wr_rec), .ts(ts_now)
   );

   rhs_store #(.REC_W(REC_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rec(wr_rec),
      .clr(clr), .rd_idx(AW'(rptr)), .rd_rec(rd_rec),
      .cnt(rec_cnt), .ovf(ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         rptr  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start_go) state <= ST_TRAIN;
               else if (rd_req) begin
                  state <= ST_READ;
                  rptr  <= '0;
               end
            end
            ST_TRAIN: if (stop_go) state <= ST_IDLE;
            ST_READ: begin
               if (take) begin
                  if (at_trailer) begin
                     state <= ST_IDLE;
                     rptr  <= '0;
                  end else begin
                     rptr <= rptr + CW'(1);
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rhs_checker.sv
module rhs_checker #(
   parameter int TS_W  = 13,
   parameter int OUT_W = 31,
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xing,
   input logic             in_train,
   input logic             stop_go,
   input logic [TS_W-1:0]  ts,
   input logic             wr_en,
   input logic [CW-1:0]    cnt,
   input logic             out_valid,
   input logic             out_ready,
   input logic             out_last,
   input logic [OUT_W-1:0] out_data
);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   p_empty_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> cnt == '0 && !out_valid);

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));

   p_standby_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !out_valid);

   p_ts_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_train && xing && !stop_go && ts == {TS_W{1'b1}} |=> ts == {TS_W{1'b1}});

   p_ts_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_train && xing && !stop_go && ts != {TS_W{1'b1}} |=> ts == $past(ts) + TS_W'(1));
endmodule

bind row_hit_sparsifier rhs_checker #(
   .TS_W(TS_W), .OUT_W(OUT_W), .DEPTH(DEPTH), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .xing(xing), .in_train(in_train),
   .stop_go(stop_go), .ts(ts_now), .wr_en(wr_en), .cnt(rec_cnt),
   .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
   .out_data(out_data)
);

// File: tb/row_hit_sparsifier_test.sv
module row_hit_sparsifier_test;
   localparam int PIX = 42;
   localparam logic [8:0] ROW = 9'h15A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic train_start = 0, train_stop = 0, xing = 0;
   logic [PIX-1:0] hit = '0;
   logic mask_din = 0, mask_shift = 0, rd_req = 0, out_ready = 1;
   logic out_valid, out_last, out_ovf;
   logic [30:0] out_data;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   logic [30:0] exp_q[$];
   logic [PIX-1:0] mdl_mask = '0;
   int bts = 0;
   bit in_tr = 0;

   localparam logic [PIX-1:0] VEC [0:5] = '{
      42'h000_0000_0000, 42'h000_0000_0001, 42'h3FF_FFFF_FFFF,
      42'h200_0000_0000, 42'h000_0000_0FC0, 42'h001_0000_0040 };

   always #10 clk = ~clk;

   row_hit_sparsifier uut (
      .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_stop(train_stop),
      .xing(xing), .hit(hit), .mask_din(mask_din), .mask_shift(mask_shift),
      .rd_req(rd_req), .row_addr(ROW), .out_ready(out_ready),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ovf(out_ovf)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model(input logic [PIX-1:0] h);
      for (int g = 0; g < 7; g++) begin
         logic [5:0] p;
         p = h[g*6 +: 6] & ~mdl_mask[g*6 +: 6];
         if (p != 0) exp_q.push_back({ROW, 13'(bts), 3'(g), p});
      end
   endtask

   task automatic do_x(input logic [PIX-1:0] h);
      @(negedge clk); hit = h; xing = 1;
      @(negedge clk); xing = 0; hit = '0;
      if (in_tr) begin
         model(h);
         bts = (bts == 8191) ? 8191 : bts + 1;
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic start_tr;
      @(negedge clk); train_start = 1;
      @(negedge clk); train_start = 0;
      in_tr = 1; bts = 0;
   endtask

   task automatic stop_tr;
      @(negedge clk); train_stop = 1;
      @(negedge clk); train_stop = 0;
      in_tr = 0;
   endtask

   task automatic load_mask(input logic [PIX-1:0] m, input bit upd);
      for (int i = PIX - 1; i >= 0; i--) begin
         @(negedge clk); mask_shift = 1; mask_din = m[i];
      end
      @(negedge clk); mask_shift = 0; mask_din = 0;
      if (upd) mdl_mask = m;
   endtask

   task automatic readout(input bit exp_ovf, input string req);
      int n = 0;
      @(negedge clk); rd_req = 1;
      @(negedge clk); rd_req = 0;
      for (int k = 0; k <= exp_q.size(); k++) begin
         chk(out_valid === 1'b1, req, 64'(out_valid), 64'd1);
         if (k < exp_q.size()) begin
            chk(out_data === exp_q[k], req, 64'(out_data), 64'(exp_q[k]));
            chk(out_last === 1'b0, req, 64'(out_last), 64'd0);
         end else begin
            chk(out_last === 1'b1, {req, " R10 trailer"}, 64'(out_last), 64'd1);
            chk(out_data === {ROW, 22'b0}, {req, " R10 trailer"}, 64'(out_data), 64'({ROW, 22'b0}));
         end
         chk(out_ovf === exp_ovf, {req, " R8 ovf"}, 64'(out_ovf), 64'(exp_ovf));
         n++;
         @(negedge clk);
      end
      chk(out_valid === 1'b0, {req, " R10 end"}, 64'(out_valid), 64'd0);
      exp_q.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [30:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk(out_valid === 1'b0, "R1 valid", 64'(out_valid), 64'd0);
      readout(1'b0, "R1 empty readout");

      // R2/R3/R6: table of hit vectors in one train
      start_tr();
      for (int v = 0; v < 6; v++) do_x(VEC[v]);
      stop_tr();
      readout(1'b0, "R2 R3 R6 table");

      // R9: crossings outside a train
      do_x(42'h3FF_FFFF_FFFF);
      readout(1'b0, "R9 idle crossing");

      // R11: read request in a train ignored
      start_tr();
      @(negedge clk); rd_req = 1;
      @(negedge clk); rd_req = 0;
      chk(out_valid === 1'b0, "R11 rd in train", 64'(out_valid), 64'd0);
      @(negedge clk);
      chk(out_valid === 1'b0, "R11 rd in train", 64'(out_valid), 64'd0);
      stop_tr();

      // R4: mask pixels 0 and 13
      load_mask(42'h000_0000_2001, 1'b1);
      start_tr();
      do_x(42'h000_0000_6001);
      // R5: shifting during a train leaves mask unchanged
      load_mask(42'h3FF_FFFF_FFFF, 1'b0);
      do_x(42'h3FF_FFFF_FFFF);
      stop_tr();
      readout(1'b0, "R4 R5 mask");
      load_mask('0, 1'b1);

      // R10: hold while not ready
      start_tr();
      do_x(42'h000_0000_0FFF);
      stop_tr();
      out_ready = 0;
      @(negedge clk); rd_req = 1;
      @(negedge clk); rd_req = 0;
      held = out_data;
      chk(out_data === exp_q[0], "R10 first word", 64'(out_data), 64'(exp_q[0]));
      @(negedge clk);
      chk(out_valid === 1'b1 && out_data === held, "R10 hold", 64'(out_data), 64'(held));
      out_ready = 1;
      @(negedge clk);
      chk(out_data === exp_q[1], "R10 second word", 64'(out_data), 64'(exp_q[1]));
      @(negedge clk);
      chk(out_last === 1'b1, "R10 last", 64'(out_last), 64'd1);
      @(negedge clk);
      chk(out_valid === 1'b0, "R10 done", 64'(out_valid), 64'd0);
      exp_q.delete();

      // R8: overflow, 21 records into 16 entries
      start_tr();
      for (int i = 0; i < 3; i++) do_x(42'h3FF_FFFF_FFFF);
      stop_tr();
      while (exp_q.size() > 16) void'(exp_q.pop_back());
      readout(1'b1, "R8 overflow");
      readout(1'b0, "R10 ovf cleared");

      // R7: timestamp saturation
      start_tr();
      for (int i = 0; i < 8200; i++) begin
         @(negedge clk); xing = 1;
         @(negedge clk); xing = 0;
         bts = (bts == 8191) ? 8191 : bts + 1;
      end
      do_x(42'h000_0000_0001);
      do_x(42'h000_0000_0002);
      stop_tr();
      readout(1'b0, "R7 saturate");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule